// File: doc/BRIEF.md
# Circular Trace Log Buffer

This block keeps a rolling history of a processor core's internal status. Every clock, while logging runs, a 256-bit status word taken from `entry_i` is stored in a circular RAM. The RAM depth is a power of two, 512 entries by default. When the write index reaches the last entry it goes back to zero, and a lap flag inverts each time that happens. The current write position is always visible on `wr_addr_o`: the index sits in the low bits, a marker 1 sits just above it, and every higher bit is zero.

The stored history can be read in two ways. Each read returns one 64-bit doubleword of an entry. Address bits [1:0] pick the doubleword, and the bits just above them pick the entry.
- **Core port.** A free-running port driven by `core_addr_i`, with the result on `core_data_o`.
- **Debug port.** A small register interface with an address register (select 0) and a data register (select 1). Writing the address register launches a read, and the result lands in the data register. Every access to the data register also moves the address on to the next doubleword when the access ends, so a debugger can stream the buffer out.

Setting bit 31 of either read address freezes logging, so the content stays put while it is inspected. With `LOG_LENGTH` set to 0 the block holds no RAM at all.

Top module: `trace_log`

## Requirements
- R1: While logging is enabled, each clock stores `entry_i` at the write index and advances the index by one. `wr_addr_o` carries the index in bits [IB-1:0], where IB = log2(LOG_LENGTH), a 1 at bit IB, and zeros above.
- R2: Reset behaviour. While `rst` is high, no entry is written. After reset, the write index, the lap flag, the debug address, the debug data register and `core_data_o` are all zero.
- R3: When a write happens at index LOG_LENGTH-1, the index wraps to 0 and `lap_o` inverts. `lap_o` changes at no other time.
- R4: While `core_addr_i[31]` is 1, no entry is written, and `wr_addr_o` and `lap_o` hold.
- R5: While bit 31 of the debug address register is 1, no entry is written, and `wr_addr_o` and `lap_o` hold.
- R6: `core_data_o` shows bits [64*d+63 : 64*d] of the entry at index `core_addr_i[IB+1:2]`, where d = `core_addr_i[1:0]`. The value appears three rising edges after the address is presented.
- R7: A write access to select 0 loads `reg_wdata_i` into the debug address. The doubleword it names appears in the data register three edges after the edge that accepted the write. A read access to select 1 returns the data register.
- R8: On the edge at which a debug result lands, `core_data_o` keeps its previous value.
- R9: At the end of any access to select 1 (the falling edge of `reg_req_i`), the low IB+2 bits of the debug address advance by one and wrap within that field, the higher bits keep their value, and a new debug read starts.
- R10: Only the cycle in which `reg_req_i` rises acts on the registers. A held request is not repeated. `reg_ack_o` follows `reg_req_i` in the same cycle. A read access to select 0 returns `{wr_addr_o, debug address}`.
- R11: With LOG_LENGTH = 0, `core_data_o` is 0 and `wr_addr_o` is the constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_i | input | 256 | Core status word logged each cycle |
| core_addr_i | input | 32 | Core-side read address; bit 31 freezes logging |
| core_data_o | output | 64 | Core-side read doubleword |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Access is a write |
| reg_sel_i | input | 1 | 0 selects the address register, 1 selects the data register |
| reg_wdata_i | input | 32 | Write data for the address register |
| reg_ack_o | output | 1 | Access acknowledge |
| reg_rdata_o | output | 64 | Register read data |
| wr_addr_o | output | 32 | Current write address: index, marker bit, zeros |
| lap_o | output | 1 | Wrap toggle |

## Verification
Core reads settle three rising edges after the address changes: index latch, RAM read, doubleword select. A debug read completes on the third edge after the edge that started it. An auto-increment starts that read two edges after the request falls. Freeze and pointer effects show one edge after the controlling bit changes. The bench changes inputs on falling edges, counts the exact number of rising edges for each result, and samples one falling edge later. Its reference image of the RAM is built from the bench's own record of which cycles were enabled.

// File: rtl/trace_log_pkg.sv
package trace_log_pkg;

    localparam int DWORD_W    = 64;
    localparam int DW_PER_ENT = 4;
    localparam int ENTRY_W    = DWORD_W * DW_PER_ENT;
    localparam int LADDR_W    = 32;
    localparam int FREEZE_BIT = LADDR_W - 1;

    typedef logic [DWORD_W-1:0] dword_t;
    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic {
        SEL_ADDR = 1'b0,
        SEL_DATA = 1'b1
    } tl_sel_e;

    typedef struct packed {
        logic reading;
        logic done;
    } rd_pipe_t;

    function automatic dword_t pick_dword(entry_t e, logic [1:0] which);
        return e[which * DWORD_W +: DWORD_W];
    endfunction

endpackage

// File: rtl/tlog_wptr.sv
module tlog_wptr #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    output logic [IDX_W-1:0] ptr_o,
    output logic             lap_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= '0;
            lap_o <= 1'b0;
        end else if (en_i) begin
            ptr_o <= ptr_o + 1'b1;
            if (ptr_o == '1) begin
                lap_o <= ~lap_o;
            end
        end
    end

endmodule

// File: rtl/tlog_ram.sv
module tlog_ram
    import trace_log_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  entry_t           wdata_i,
    input  logic [IDX_W-1:0] raddr_i,
    output entry_t           rdata_o
);

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/tlog_rd.sv
module tlog_rd
    import trace_log_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [IDX_W-1:0] dbg_idx_i,
    input  logic [1:0]       dbg_dw_i,
    input  logic [IDX_W-1:0] core_idx_i,
    input  logic [1:0]       core_dw_i,
    output logic [IDX_W-1:0] ram_idx_o,
    input  entry_t           ram_q_i,
    output dword_t           dbg_data_o,
    output dword_t           core_data_o
);

    rd_pipe_t pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe        <= '0;
            ram_idx_o   <= '0;
            dbg_data_o  <= '0;
            core_data_o <= '0;
        end else begin
            ram_idx_o    <= start_i ? dbg_idx_i : core_idx_i;
            pipe.reading <= start_i;
            pipe.done    <= pipe.reading;
            if (pipe.done) begin
                dbg_data_o <= pick_dword(ram_q_i, dbg_dw_i);
            end else begin
                core_data_o <= pick_dword(ram_q_i, core_dw_i);
            end
        end
    end

endmodule

// File: rtl/tlog_regif.sv
module tlog_regif
    import trace_log_pkg::*;
#(
    parameter int INC_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic               we_i,
    input  logic               sel_i,
    input  logic [LADDR_W-1:0] wdata_i,
    output logic [LADDR_W-1:0] addr_o,
    output logic               start_o
);

    logic req_q;
    logic dacc_q;
    logic dacc_q1;
    logic rise;

    assign rise = req_i && !req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            dacc_q  <= 1'b0;
            dacc_q1 <= 1'b0;
            addr_o  <= '0;
            start_o <= 1'b0;
        end else begin
            req_q   <= req_i;
            dacc_q  <= req_i && (tl_sel_e'(sel_i) == SEL_DATA);
            dacc_q1 <= dacc_q;
            start_o <= 1'b0;
            if (rise) begin
                if (we_i && (tl_sel_e'(sel_i) == SEL_ADDR)) begin
                    addr_o  <= wdata_i;
                    start_o <= 1'b1;
                end
            end else if (dacc_q1 && !dacc_q) begin
                addr_o[INC_W-1:0] <= addr_o[INC_W-1:0] + 1'b1;
                start_o           <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/trace_log.sv
module trace_log
    import trace_log_pkg::*;
#(
    parameter int LOG_LENGTH = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic [LADDR_W-1:0] core_addr_i,
    output logic [DWORD_W-1:0] core_data_o,
    input  logic               reg_req_i,
    input  logic               reg_we_i,
    input  logic               reg_sel_i,
    input  logic [LADDR_W-1:0] reg_wdata_i,
    output logic               reg_ack_o,
    output logic [DWORD_W-1:0] reg_rdata_o,
    output logic [LADDR_W-1:0] wr_addr_o,
    output logic               lap_o
);

    localparam int IDX_W = (LOG_LENGTH > 1) ? $clog2(LOG_LENGTH) : 0;
    localparam int PTR_W = (IDX_W > 0) ? IDX_W : 1;

    logic [LADDR_W-1:0] dbg_addr;
    logic               dbg_start;
    dword_t             dbg_data;

    tlog_regif #(.INC_W(IDX_W + 2)) u_regif (
        .clk     (clk),
        .rst     (rst),
        .req_i   (reg_req_i),
        .we_i    (reg_we_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .addr_o  (dbg_addr),
        .start_o (dbg_start)
    );

    generate
        if (LOG_LENGTH > 0) begin : g_log
            logic       wr_en;
            logic [PTR_W-1:0] wptr;
            logic [PTR_W-1:0] ridx;
            entry_t     ram_q;
            logic       unused_core_hi;

            assign wr_en = !rst && !core_addr_i[FREEZE_BIT] && !dbg_addr[FREEZE_BIT];
            assign unused_core_hi = ^core_addr_i[LADDR_W-2:IDX_W+2];

            tlog_wptr #(.IDX_W(PTR_W)) u_wptr (
                .clk   (clk),
                .rst   (rst),
                .en_i  (wr_en),
                .ptr_o (wptr),
                .lap_o (lap_o)
            );

            tlog_ram #(.DEPTH(LOG_LENGTH), .IDX_W(PTR_W)) u_ram (
                .clk     (clk),
                .we_i    (wr_en),
                .waddr_i (wptr),
                .wdata_i (entry_i),
                .raddr_i (ridx),
                .rdata_o (ram_q)
            );

            tlog_rd #(.IDX_W(PTR_W)) u_rd (
                .clk         (clk),
                .rst         (rst),
                .start_i     (dbg_start),
                .dbg_idx_i   (dbg_addr[IDX_W+1:2]),
                .dbg_dw_i    (dbg_addr[1:0]),
                .core_idx_i  (core_addr_i[IDX_W+1:2]),
                .core_dw_i   (core_addr_i[1:0]),
                .ram_idx_o   (ridx),
                .ram_q_i     (ram_q),
                .dbg_data_o  (dbg_data),
                .core_data_o (core_data_o)
            );

            always_comb begin
                wr_addr_o             = '0;
                wr_addr_o[IDX_W]      = 1'b1;
                wr_addr_o[IDX_W-1:0]  = wptr;
            end
        end else begin : g_nolog
            logic unused_inputs;
            assign unused_inputs = ^{entry_i, core_addr_i, dbg_start};
            assign core_data_o   = '0;
            assign dbg_data      = '0;
            assign lap_o         = 1'b0;
            assign wr_addr_o     = LADDR_W'(1);
        end
    endgenerate

    assign reg_ack_o   = reg_req_i;
    assign reg_rdata_o = (tl_sel_e'(reg_sel_i) == SEL_DATA) ? dbg_data : {wr_addr_o, dbg_addr};

endmodule

// File: rtl/tlog_checker.sv
module tlog_checker #(
    parameter int LOG_LENGTH = 512,
    parameter int PW = (LOG_LENGTH > 1) ? $clog2(LOG_LENGTH) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          core_frz,
    input logic          dbg_frz,
    input logic [PW-1:0] wr_ptr,
    input logic          lap
);

    generate
        if (LOG_LENGTH > 0) begin : g_chk
            logic en;
            assign en = !core_frz && !dbg_frz;

            AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
                en |=> (wr_ptr == PW'($past(wr_ptr) + 1'b1)));  // R1

            AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (wr_ptr == '0 && !lap));  // R2

            AST_LAP_FLIP: assert property (@(posedge clk) disable iff (rst)
                (en && wr_ptr == '1) |=> (lap != $past(lap)));  // R3

            AST_LAP_KEEP: assert property (@(posedge clk) disable iff (rst)
                !(en && wr_ptr == '1) |=> $stable(lap));  // R3

            AST_CORE_FREEZE: assert property (@(posedge clk) disable iff (rst)
                core_frz |=> ($stable(wr_ptr) && $stable(lap)));  // R4

            AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (rst)
                dbg_frz |=> ($stable(wr_ptr) && $stable(lap)));  // R5
        end
    endgenerate

endmodule

bind trace_log tlog_checker #(.LOG_LENGTH(LOG_LENGTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .core_frz (core_addr_i[31]),
    .dbg_frz  (dbg_addr[31]),
    .wr_ptr   (wr_addr_o[((LOG_LENGTH > 1) ? $clog2(LOG_LENGTH) : 1)-1:0]),
    .lap      (lap_o)
);

// File: tb/trace_log_bench.sv
`timescale 1ns/1ps
module trace_log_bench;

    localparam int LEN = 512;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] entry_i = '0;
    logic [31:0]  core_addr = '0;
    logic         req = 1'b0, we = 1'b0, sel = 1'b0;
    logic [31:0]  wdata = '0;
    logic [63:0]  core_data, rdata, nl_core_data, nl_rdata;
    logic         ack, lap, nl_ack, nl_lap;
    logic [31:0]  wr_addr, nl_wr_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trace_log #(.LOG_LENGTH(LEN)) u_trace_log (
        .clk(clk), .rst(rst), .entry_i(entry_i), .core_addr_i(core_addr),
        .core_data_o(core_data), .reg_req_i(req), .reg_we_i(we), .reg_sel_i(sel),
        .reg_wdata_i(wdata), .reg_ack_o(ack), .reg_rdata_o(rdata),
        .wr_addr_o(wr_addr), .lap_o(lap));

    trace_log #(.LOG_LENGTH(0)) u_trace_log_nolog (
        .clk(clk), .rst(rst), .entry_i(entry_i), .core_addr_i(core_addr),
        .core_data_o(nl_core_data), .reg_req_i(req), .reg_we_i(we), .reg_sel_i(sel),
        .reg_wdata_i(wdata), .reg_ack_o(nl_ack), .reg_rdata_o(nl_rdata),
        .wr_addr_o(nl_wr_addr), .lap_o(nl_lap));

    // reference image of the log
    logic [255:0] model [LEN];
    int  m_ptr = 0;
    int  m_writes = 0;
    bit  m_dbg31 = 0;
    bit  m_req_q = 0;
    int unsigned stamp = 0;

    function automatic logic [255:0] mk(int unsigned s);
        logic [255:0] e;
        for (int k = 0; k < 4; k++) begin
            e[k*64 +: 64] = {8'(8'hA0 + k), 24'(s), 32'(s * 7 + k)};
        end
        return e;
    endfunction

    function automatic logic [63:0] exp_dw(int idx, int dw);
        return model[idx % LEN][dw*64 +: 64];
    endfunction

    always @(negedge clk) begin
        stamp   <= stamp + 1;
        entry_i <= mk(stamp);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_ptr = 0; m_writes = 0; m_dbg31 = 0; m_req_q = 0;
        end else begin
            if (!core_addr[31] && !m_dbg31) begin
                model[m_ptr] = entry_i;
                m_ptr = (m_ptr + 1) % LEN;
                m_writes++;
            end
            if (req && !m_req_q && we && !sel) m_dbg31 = wdata[31];
            m_req_q = req;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // write the debug address register; returns at the negedge after the result landed
    task automatic dbg_set_addr(logic [31:0] a);
        @(negedge clk); req = 1; we = 1; sel = 0; wdata = a;
        @(negedge clk); req = 0; we = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_dbg_data(output logic [63:0] d);
        sel = 1; #1; d = rdata;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        cycles(3);
        chk("R2 wr_addr in reset", 64'(wr_addr), 64'h200);
        chk("R2 lap in reset", 64'(lap), 0);
        chk("R2 core data", core_data, 0);
        read_dbg_data(d);
        chk("R2 debug data", d, 0);
        sel = 0; #1;
        chk("R10 addr readback", rdata, {32'h200, 32'h0});
        chk("R11 nolog wr_addr", 64'(nl_wr_addr), 1);
        chk("R11 nolog core data", nl_core_data, 0);
        rst = 0;
    endtask

    task automatic t_run_wrap;
        logic [31:0] a;
        core_addr = 0;
        cycles(2);
        chk("R1 first writes", 64'(wr_addr), 64'(32'h200 | m_ptr));
        a = wr_addr;
        cycles(1);
        chk("R1 step", 64'(wr_addr), 64'(32'h200 | ((a + 1) & 32'h1FF)));
        cycles(600);
        chk("R3 wrap index", 64'(wr_addr), 64'(32'h200 | m_ptr));
        chk("R3 lap set", 64'(lap), 64'((m_writes / LEN) % 2));
        chk("R3 lap expected one", 64'(lap), 1);
    endtask

    task automatic t_core_freeze;
        logic [31:0] a0;
        int ents [5];
        ents = '{0, 1, 300, 511, (m_ptr + LEN - 1) % LEN};
        @(negedge clk); core_addr = 32'h8000_0000;
        cycles(3);
        a0 = wr_addr;
        cycles(10);
        chk("R4 pointer frozen", 64'(wr_addr), 64'(a0));
        foreach (ents[i]) begin
            for (int dw = 0; dw < 4; dw++) begin
                core_addr = 32'h8000_0000 | 32'(ents[i] << 2) | 32'(dw);
                repeat (3) @(posedge clk);
                @(negedge clk);
                chk($sformatf("R6 core read e%0d d%0d", ents[i], dw), core_data, exp_dw(ents[i], dw));
            end
        end
        chk("R11 nolog core read", nl_core_data, 0);
    endtask

    task automatic t_arbitrate;
        logic [63:0] d;
        core_addr = 32'h8000_0000 | (32'd10 << 2) | 32'd1;
        cycles(4);
        dbg_set_addr((32'd20 << 2) | 32'd2);
        chk("R8 core held", core_data, exp_dw(10, 1));
        read_dbg_data(d);
        chk("R7 debug read", d, exp_dw(20, 2));
    endtask

    task automatic t_autoinc;
        logic [63:0] d;
        @(negedge clk); req = 1; we = 0; sel = 1;
        @(negedge clk); req = 0;
        cycles(8);
        sel = 0; #1;
        chk("R9 addr step", 64'(rdata[31:0]), 64'((32'd20 << 2) | 32'd3));
        read_dbg_data(d);
        chk("R9 next dword", d, exp_dw(20, 3));
        @(negedge clk); req = 1;
        @(negedge clk); req = 0;
        cycles(8);
        read_dbg_data(d);
        chk("R9 entry crossing", d, exp_dw(21, 0));
        dbg_set_addr(32'h0001_07FF);
        @(negedge clk); req = 1; sel = 1;
        @(negedge clk); req = 0;
        cycles(8);
        sel = 0; #1;
        chk("R9 field wrap", 64'(rdata[31:0]), 64'h0001_0000);
        read_dbg_data(d);
        chk("R9 wrapped data", d, exp_dw(0, 0));
    endtask

    task automatic t_dbg_freeze;
        logic [31:0] a0;
        logic [63:0] d;
        @(negedge clk); core_addr = 0;
        dbg_set_addr(32'h0);
        cycles(20);
        dbg_set_addr(32'h8000_0000 | (32'd5 << 2));
        a0 = wr_addr;
        cycles(10);
        chk("R5 pointer frozen", 64'(wr_addr), 64'(a0));
        chk("R5 model frozen", 64'(wr_addr), 64'(32'h200 | m_ptr));
        read_dbg_data(d);
        chk("R5 debug read e5", d, exp_dw(5, 0));
        for (int dw = 0; dw < 4; dw++) begin
            dbg_set_addr(32'h8000_0000 | (32'd400 << 2) | 32'(dw));
            read_dbg_data(d);
            chk($sformatf("R7 debug read e400 d%0d", dw), d, exp_dw(400, dw));
        end
        core_addr = (32'd401 << 2) | 32'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 core read while debug frozen", core_data, exp_dw(401, 3));
    endtask

    task automatic t_held_req;
        @(negedge clk); req = 1; we = 1; sel = 0; wdata = 32'h8000_0123;
        #1; chk("R10 ack follows req", 64'(ack), 1);
        @(negedge clk); wdata = 32'h8000_0456;
        @(negedge clk); wdata = 32'h8000_0789;
        @(negedge clk); req = 0; we = 0;
        #1; chk("R10 ack drops", 64'(ack), 0);
        cycles(4);
        sel = 0; #1;
        chk("R10 held request acts once", 64'(rdata[31:0]), 64'h8000_0123);
    endtask

    task automatic t_resume;
        logic [31:0] a;
        dbg_set_addr(32'h0);
        cycles(2);
        a = wr_addr;
        cycles(1);
        chk("R1 resumes", 64'(wr_addr), 64'(32'h200 | ((a + 1) & 32'h1FF)));
        chk("R1 model match", 64'(wr_addr), 64'(32'h200 | m_ptr));
    endtask

    bit done = 0;

    initial begin
        t_reset();
        t_run_wrap();
        t_core_freeze();
        t_arbitrate();
        t_autoinc();
        t_dbg_freeze();
        t_held_req();
        t_resume();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule